// File: doc/BRIEF.md
# Masked-Write Control Register Bank

This block holds a small set of 16-bit control registers and serves them over a simple 32-bit register bus. Each register has a fixed attribute, chosen per register by a parameter, that gives it one of two write behaviours. A masked register treats the upper half of a write word as a per-bit update enable for the lower half. Software can then set or clear individual bits in one bus write. It needs no prior read and no copy of the register held in software. A plain register stores the lower half of every write and ignores the upper half.

The bus runs at one access per cycle. A read request returns its data, together with a valid strobe, on the cycle after the request. A read reports the stored value only; the enable half of any write plays no part in it. Addresses beyond the last register read as zero, and writes to them are dropped. A synchronous reset loads each register with its own parameterised value.

Top module: `mwreg_bank`

## Requirements
- R1: On a masked register, write-data bit 16+i enables an update of stored bit i to write-data bit i. For example, writing 0x00010001 sets bit 0 and leaves the other fifteen bits as they were.
- R2: On a masked register, a bit is cleared by setting its enable with a zero data bit. For example, 0x00010000 clears bit 0 and 0x10000000 clears bit 12, with all other bits unchanged.
- R3: A write to a masked register whose bits 31:16 are all zero leaves that register completely unchanged, whatever bits 15:0 hold.
- R4: A write to a plain register stores write-data bits 15:0 in full and ignores bits 31:16.
- R5: A read request in cycle N gives bus_rvalid=1 in cycle N+1, with the stored value in bus_rdata[15:0] and zero in bus_rdata[31:16]. In a cycle that follows no read request, bus_rvalid=0 and bus_rdata=0.
- R6: With the default 4-bit word address, addresses 8 to 15 are unmapped. A read there returns zero with bus_rvalid=1, and a write there changes no register.
- R7: While rst is high at a clock edge, register i loads its reset value and bus_rvalid goes to 0. The default reset value of register i is 0x1111 times i (0x0000, 0x1111, … 0x7777).
- R8: When a read and a write hit the same register in the same cycle, the read returns the value held before that write. The write still takes effect and is visible to the next read.
- R9: The masked attribute is a per-register parameter bit. By default registers 0, 1, 4 and 6 are masked and registers 2, 3, 5 and 7 are plain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (4) | Register word address |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_rd | input | 1 | Read request for this cycle |
| bus_wdata | input | 32 | Write data; on masked registers the upper half holds the bit enables |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |

## Verification
A read and a write can target the same register in the same cycle. The read path and the register update then act on one clock edge. The bench provokes this on a plain register and on a masked register by raising bus_rd and bus_wr together at one address. The scoreboard expects the value from before the write on the read result, and it issues a follow-up read that must show the written or merged value. This shows that the read sampled the old state while the update still landed.

// File: rtl/mwreg_pkg.sv
package mwreg_pkg;

    localparam int unsigned MW_HALF_W = 16;
    localparam int unsigned MW_BUS_W  = 2 * MW_HALF_W;

    typedef struct packed {
        logic                vld;
        logic [MW_BUS_W-1:0] data;
    } rd_resp_t;

endpackage

// File: rtl/mwreg_decode.sv
module mwreg_decode #(
    parameter int unsigned NREGS  = 8,
    parameter int unsigned ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NREGS-1:0]  sel
);

    for (genvar g = 0; g < NREGS; g++) begin : g_sel
        assign sel[g] = (addr == ADDR_W'(g));
    end

endmodule

// File: rtl/mwreg_cell.sv
module mwreg_cell
    import mwreg_pkg::*;
#(
    parameter bit                  MASKED  = 1'b0,
    parameter logic [MW_HALF_W-1:0] RST_VAL = '0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [MW_BUS_W-1:0]   wdata,
    output logic [MW_HALF_W-1:0]  value
);

    logic [MW_HALF_W-1:0] val_d, val_q;
    logic [MW_HALF_W-1:0] upd_bits;
    logic [MW_HALF_W-1:0] new_bits;

    assign new_bits = wdata[MW_HALF_W-1:0];

    if (MASKED) begin : g_masked
        assign upd_bits = wdata[MW_BUS_W-1:MW_HALF_W];
    end else begin : g_plain
        logic unused_upper;
        assign unused_upper = ^wdata[MW_BUS_W-1:MW_HALF_W];
        assign upd_bits     = '1;
    end

    always_comb begin
        val_d = val_q;
        if (wr_en) begin
            val_d = (val_q & ~upd_bits) | (new_bits & upd_bits);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q <= RST_VAL;
        end else begin
            val_q <= val_d;
        end
    end

    assign value = val_q;

endmodule

// File: rtl/mwreg_rdmux.sv
module mwreg_rdmux
    import mwreg_pkg::*;
#(
    parameter int unsigned NREGS = 8
) (
    input  logic [NREGS-1:0]                 sel,
    input  logic [NREGS-1:0][MW_HALF_W-1:0]  vals,
    output logic [MW_HALF_W-1:0]             rd_val
);

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NREGS; i++) begin
            rd_val = rd_val | (vals[i] & {MW_HALF_W{sel[i]}});
        end
    end

endmodule

// File: rtl/mwreg_bank.sv
module mwreg_bank
    import mwreg_pkg::*;
#(
    parameter int unsigned                    NREGS      = 8,
    parameter int unsigned                    ADDR_W     = 4,
    parameter logic [NREGS-1:0]               MASKED_MAP = 8'b0101_0011,
    parameter logic [NREGS*MW_HALF_W-1:0]     RST_VALS   = {16'h7777, 16'h6666, 16'h5555, 16'h4444,
                                                            16'h3333, 16'h2222, 16'h1111, 16'h0000}
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [MW_BUS_W-1:0]  bus_wdata,
    output logic [MW_BUS_W-1:0]  bus_rdata,
    output logic                 bus_rvalid
);

    logic [NREGS-1:0]                sel;
    logic [NREGS-1:0]                wr_sel;
    logic [NREGS-1:0][MW_HALF_W-1:0] reg_vals;
    logic [MW_HALF_W-1:0]            rd_val;
    rd_resp_t                        resp_d, resp_q;

    mwreg_decode #(
        .NREGS  (NREGS),
        .ADDR_W (ADDR_W)
    ) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign wr_sel = sel & {NREGS{bus_wr}};

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        mwreg_cell #(
            .MASKED  (MASKED_MAP[g]),
            .RST_VAL (RST_VALS[g*MW_HALF_W +: MW_HALF_W])
        ) u_cell (
            .clk   (clk),
            .rst   (rst),
            .wr_en (wr_sel[g]),
            .wdata (bus_wdata),
            .value (reg_vals[g])
        );
    end

    mwreg_rdmux #(
        .NREGS (NREGS)
    ) u_rdmux (
        .sel    (sel),
        .vals   (reg_vals),
        .rd_val (rd_val)
    );

    always_comb begin
        resp_d      = '0;
        resp_d.vld  = bus_rd;
        if (bus_rd) begin
            resp_d.data = {{MW_HALF_W{1'b0}}, rd_val};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign bus_rdata  = resp_q.data;
    assign bus_rvalid = resp_q.vld;

endmodule

// File: rtl/mwreg_bank_chk.sv
module mwreg_bank_chk #(
    parameter int unsigned NREGS  = 8,
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic [31:0]       bus_rdata,
    input logic              bus_rvalid
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NREGS - 1);

    // R5
    rd_gives_valid_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> bus_rvalid);

    // R5
    no_rd_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> !bus_rvalid);

    // R5
    upper_half_zero_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rvalid |-> (bus_rdata[31:16] == 16'h0000));

    // R5
    idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rvalid |-> (bus_rdata == 32'h0));

    // R6
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (bus_addr > LAST_ADDR)) |=> (bus_rdata == 32'h0));

    // R7
    reset_clears_valid_chk: assert property (@(posedge clk)
        rst |=> !bus_rvalid);

endmodule

bind mwreg_bank mwreg_bank_chk #(
    .NREGS  (NREGS),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid)
);

// File: tb/mwreg_bank_tb.sv
`timescale 1ns/1ps
module mwreg_bank_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;

    always #2 clk = ~clk;

    mwreg_bank u_dut (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid)
    );

    typedef struct {
        int          due;
        bit          vld;
        logic [31:0] data;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          cyc = 0;
    int          n_vec = 0;
    int          n_bad = 0;
    logic [15:0] mdl [8];
    // R9: registers 0, 1, 4, 6 masked
    localparam logic [7:0] R9_MASKED = 8'b0101_0011;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] rd_exp(input logic [3:0] a);
        return (a < 4'd8) ? {16'h0000, mdl[a[2:0]]} : 32'h0;
    endfunction

    task automatic load_reset_model();
        for (int i = 0; i < 8; i++) mdl[i] = 16'(16'h1111 * i);
    endtask

    task automatic push(input bit vld, input logic [31:0] data, input string tag);
        exp_t e;
        e.due = cyc + 1; e.vld = vld; e.data = data; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic do_reset(input string tag);
        @(posedge clk); #1;
        rst = 1'b1; bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        push(1'b0, 32'h0, tag);
        load_reset_model();
    endtask

    task automatic access(input bit rd, input bit wr, input logic [3:0] a,
                          input logic [31:0] d, input string tag);
        @(posedge clk); #1;
        rst = 1'b0; bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
        push(rd, rd ? rd_exp(a) : 32'h0, tag);
        if (wr && a < 4'd8) begin
            if (R9_MASKED[a[2:0]])
                mdl[a[2:0]] = (mdl[a[2:0]] & ~d[31:16]) | (d[15:0] & d[31:16]);
            else
                mdl[a[2:0]] = d[15:0];
        end
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        access(1'b1, 1'b0, a, 32'h0, tag);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
        access(1'b0, 1'b1, a, d, tag);
    endtask

    // monitor
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            e = sb.pop_front();
            n_vec++;
            if (bus_rvalid !== e.vld || bus_rdata !== e.data) begin
                n_bad++;
                $display("FAIL %s: rvalid=%0b rdata=%08h expected rvalid=%0b rdata=%08h",
                         e.tag, bus_rvalid, bus_rdata, e.vld, e.data);
            end
        end
    end

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        load_reset_model();
        do_reset("R7");
        do_reset("R7");
        // R7 reset values, R9 on every register, R6 unmapped read
        for (int i = 0; i < 8; i++) rd(4'(i), "R7");
        rd(4'd9, "R6");
        // R1 masked set
        wr(4'd0, 32'h0001_0001, "R1");
        rd(4'd0, "R1");
        wr(4'd4, 32'h000F_00FF, "R1");
        rd(4'd4, "R1");
        // R2 masked clear
        wr(4'd0, 32'h0001_0000, "R2");
        rd(4'd0, "R2");
        wr(4'd1, 32'h1000_0000, "R2");
        rd(4'd1, "R2");
        // R3 zero enables
        wr(4'd6, 32'h0000_FFFF, "R3");
        rd(4'd6, "R3");
        // R4 plain registers
        wr(4'd2, 32'hABCD_1234, "R4");
        rd(4'd2, "R4");
        wr(4'd7, 32'hFFFF_0000, "R4");
        rd(4'd7, "R4");
        wr(4'd5, 32'h0000_C3A5, "R9");
        rd(4'd5, "R9");
        // R6 unmapped writes ignored
        wr(4'd8, 32'hFFFF_BEEF, "R6");
        wr(4'd15, 32'hFFFF_FFFF, "R6");
        for (int i = 0; i < 8; i++) rd(4'(i), "R6");
        rd(4'd8, "R6");
        rd(4'd15, "R6");
        // R5 idle after reads, back-to-back reads
        access(1'b0, 1'b0, 4'd3, 32'h0, "R5");
        rd(4'd3, "R5");
        rd(4'd4, "R5");
        access(1'b0, 1'b0, 4'd4, 32'h0, "R5");
        // R8 read and write in the same cycle
        access(1'b1, 1'b1, 4'd3, 32'h0000_5A5A, "R8");
        rd(4'd3, "R8");
        access(1'b1, 1'b1, 4'd6, 32'h0001_0001, "R8");
        rd(4'd6, "R8");
        // R7 reset mid-run restores values
        do_reset("R7");
        for (int i = 0; i < 8; i++) rd(4'(i), "R7");
        access(1'b0, 1'b0, 4'd0, 32'h0, "R5");
        repeat (3) @(posedge clk);
        @(negedge clk);
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL R5: %0d results missing, expected 0", sb.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule